// File: doc/BRIEF.md
# Flash completion polling controller

This block sits on the host side of a parallel flash with an active-low output enable, an active-low write strobe, an address bus and a byte-wide data bus. A requester hands it one operation at a time: a byte program or a sector/block erase, a target address, the byte to program, and the choice of polling method. The controller first writes the fixed unlock-and-command sequence. It then reads the target address over and over until the flash shows that its internal operation has finished.

Two polling methods are offered. The bit-7 method compares data bit 7 with the value expected once the operation ends. The bit-6 method waits until bit 6 stops alternating between consecutive reads. Once completion is seen, the controller waits a settling interval while both strobes are idle, then reads the target once more and returns that byte. An address outside the valid range is rejected without any bus traffic. If no completion appears within a bounded number of reads, the operation ends with a timeout status.

The FSM states are IDLE (ready for a request), WR_LO (write strobe low with address and data driven), WR_HI (write strobe released, data held), POLL_ADDR (address set up, output enable high), POLL_READ (output enable low, status sampled), SETTLE (bus idle for the settling time), FINAL_ADDR and FINAL_READ (the data read-back), and RESP (one-cycle response). The transitions are:
- IDLE to RESP on an out-of-range request, or IDLE to WR_LO on a valid one.
- WR_LO to WR_HI.
- WR_HI back to WR_LO for the next command word, or WR_HI to POLL_ADDR after the last word.
- POLL_ADDR to POLL_READ.
- POLL_READ to SETTLE on completion, to RESP when the read budget is used up, otherwise back to POLL_ADDR.
- SETTLE to FINAL_ADDR once the settle count ends.
- FINAL_ADDR to FINAL_READ to RESP, and RESP to IDLE.

Top module: `flash_poll_ctrl`

## Requirements
- R1: `req_ready` is high only while idle. A request is taken on a cycle with `req_valid` and `req_ready` both high, after which `req_ready` stays low until the response. `done_valid` is a single-cycle pulse, and `req_ready` is high again in the following cycle.
- R2: A program writes four words as (address, data): (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0xA0), then (target address, program byte). Each write is one cycle with `fl_we_n` low, followed by one cycle with `fl_we_n` high.
- R3: An erase writes six words: (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x80), (0x5555,0xAA), (0x2AAA,0x55), then (target address, 0x30).
- R4: No read (`fl_oe_n` low) occurs before the last command write has been issued, and `fl_oe_n` and `fl_we_n` are never low in the same cycle.
- R5: In bit-7 mode (`req_toggle`=0) for a program, a read ends polling when its bit 7 equals bit 7 of the program byte.
- R6: In bit-7 mode for an erase, a read ends polling when its bit 7 is 1.
- R7: In bit-6 mode (`req_toggle`=1), a read ends polling when its bit 6 equals bit 6 of the previous poll read. The first poll read of an operation never ends polling.
- R8: After completion, both strobes stay high for SETTLE_CYC cycles. One final read of the target address follows, and its byte is returned on `done_data` with `done_status`=0 (done). The final read's output-enable cycle comes SETTLE_CYC+2 cycles after the completing poll read's.
- R9: If MAX_POLLS poll reads pass without completion, the response carries `done_status`=1 (timeout) and `done_data`=0, with no final read. A completion seen on read number MAX_POLLS still gives status 0.
- R10: A request with address >= ADDR_LIMIT is answered in the cycle after acceptance with `done_status`=2 (range error) and `done_data`=0, with no write and no read on the bus.
- R11: After reset, `req_ready`=1, `done_valid`=0, `fl_oe_n`=1, `fl_we_n`=1 and `fl_dq_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_erase | input | 1 | 1 = erase, 0 = program |
| req_toggle | input | 1 | 1 = bit-6 toggle polling, 0 = bit-7 polling |
| req_addr | input | AW | Target address |
| req_data | input | 8 | Byte to program |
| done_valid | output | 1 | Response pulse |
| done_status | output | 2 | 0 done, 1 timeout, 2 range error |
| done_data | output | 8 | Byte read back after settling |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | 8 | Data driven to the flash |
| fl_dq_oe | output | 1 | High while the controller drives the data bus |
| fl_din | input | 8 | Data returned by the flash |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |

## Verification
Two functions can land in the same POLL_READ cycle: recognising completion and running out of the read budget. This happens when the flash finishes exactly on read number MAX_POLLS. The bench sweeps the modelled busy length across that point for both polling methods and both operations. Busy lengths that put completion on the last allowed read must yield status done, a final read and the settled data. One read later, they must yield a timeout with exactly MAX_POLLS reads and no read-back.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [1:0] {
        RSP_OK      = 2'd0,
        RSP_TIMEOUT = 2'd1,
        RSP_RANGE   = 2'd2
    } rsp_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_LO,
        S_WR_HI,
        S_POLL_ADDR,
        S_POLL_READ,
        S_SETTLE,
        S_FINAL_ADDR,
        S_FINAL_READ,
        S_RESP
    } state_e;

    localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
    localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_FIRST     = 8'hAA;
    localparam logic [7:0]  KEY_SECOND    = 8'h55;
    localparam logic [7:0]  CMD_PROGRAM   = 8'hA0;
    localparam logic [7:0]  CMD_ERASE_SET = 8'h80;
    localparam logic [7:0]  CMD_ERASE_GO  = 8'h30;
    localparam int          PGM_WORDS     = 4;
    localparam int          ERS_WORDS     = 6;

endpackage

// File: rtl/fpc_cmd_table.sv
module fpc_cmd_table
    import flash_poll_pkg::*;
#(
    parameter int AW = 19
) (
    input  logic          erase,
    input  logic [2:0]    idx,
    input  logic [AW-1:0] tgt_addr,
    input  logic [7:0]    tgt_data,
    output logic [AW-1:0] word_addr,
    output logic [7:0]    word_data,
    output logic          word_last
);

    localparam logic [AW-1:0] ADDR_A = AW'(UNLOCK_ADDR_A);
    localparam logic [AW-1:0] ADDR_B = AW'(UNLOCK_ADDR_B);

    always_comb begin
        word_addr = ADDR_A;
        word_data = KEY_FIRST;
        word_last = 1'b0;
        if (!erase) begin
            unique case (idx)
                3'd0: begin word_addr = ADDR_A; word_data = KEY_FIRST;   end
                3'd1: begin word_addr = ADDR_B; word_data = KEY_SECOND;  end
                3'd2: begin word_addr = ADDR_A; word_data = CMD_PROGRAM; end
                default: begin
                    word_addr = tgt_addr;
                    word_data = tgt_data;
                    word_last = 1'b1;
                end
            endcase
        end else begin
            unique case (idx)
                3'd0: begin word_addr = ADDR_A; word_data = KEY_FIRST;     end
                3'd1: begin word_addr = ADDR_B; word_data = KEY_SECOND;    end
                3'd2: begin word_addr = ADDR_A; word_data = CMD_ERASE_SET; end
                3'd3: begin word_addr = ADDR_A; word_data = KEY_FIRST;     end
                3'd4: begin word_addr = ADDR_B; word_data = KEY_SECOND;    end
                default: begin
                    word_addr = tgt_addr;
                    word_data = CMD_ERASE_GO;
                    word_last = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/fpc_complete_eval.sv
module fpc_complete_eval (
    input  logic       toggle_mode,
    input  logic       erase,
    input  logic       want_bit7,
    input  logic       have_prev,
    input  logic       prev_bit6,
    input  logic [7:0] rd_byte,
    output logic       complete
);

    always_comb begin
        if (toggle_mode) begin
            complete = have_prev && (rd_byte[6] == prev_bit6);
        end else if (erase) begin
            complete = rd_byte[7];
        end else begin
            complete = (rd_byte[7] == want_bit7);
        end
    end

endmodule

// File: rtl/fpc_downcount.sv
module fpc_downcount #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int AW         = 19,
    parameter int ADDR_LIMIT = 2 ** 19,
    parameter int MAX_POLLS  = 4096,
    parameter int SETTLE_CYC = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_erase,
    input  logic          req_toggle,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          done_valid,
    output logic [1:0]    done_status,
    output logic [7:0]    done_data,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dout,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_din,
    output logic          fl_oe_n,
    output logic          fl_we_n
);

    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [AW:0]   LIMIT_EXT  = (AW + 1)'(ADDR_LIMIT);
    localparam logic [PW-1:0] POLL_START = PW'(MAX_POLLS - 1);
    localparam logic [SW-1:0] SETL_START = SW'(SETTLE_CYC - 1);

    state_e        state_q, state_d;
    logic          erase_q, toggle_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic [2:0]    idx_q;
    logic          prev6_q, have_prev_q;
    rsp_e          status_q;
    logic [7:0]    rdata_q;

    logic [AW-1:0] tbl_addr;
    logic [7:0]    tbl_data;
    logic          tbl_last;
    logic          complete;
    logic          budget_zero, settle_zero;
    logic          out_of_range;

    assign out_of_range = ({1'b0, req_addr} >= LIMIT_EXT);

    fpc_cmd_table #(.AW(AW)) u_table (
        .erase     (erase_q),
        .idx       (idx_q),
        .tgt_addr  (addr_q),
        .tgt_data  (data_q),
        .word_addr (tbl_addr),
        .word_data (tbl_data),
        .word_last (tbl_last)
    );

    fpc_complete_eval u_eval (
        .toggle_mode (toggle_q),
        .erase       (erase_q),
        .want_bit7   (data_q[7]),
        .have_prev   (have_prev_q),
        .prev_bit6   (prev6_q),
        .rd_byte     (fl_din),
        .complete    (complete)
    );

    fpc_downcount #(.W(PW)) u_budget (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == S_WR_HI && tbl_last),
        .load_val (POLL_START),
        .dec      (state_q == S_POLL_READ && !complete),
        .zero     (budget_zero)
    );

    fpc_downcount #(.W(SW)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == S_POLL_READ && complete),
        .load_val (SETL_START),
        .dec      (state_q == S_SETTLE),
        .zero     (settle_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (req_valid) state_d = out_of_range ? S_RESP : S_WR_LO;
            S_WR_LO:      state_d = S_WR_HI;
            S_WR_HI:      state_d = tbl_last ? S_POLL_ADDR : S_WR_LO;
            S_POLL_ADDR:  state_d = S_POLL_READ;
            S_POLL_READ: begin
                if (complete)         state_d = S_SETTLE;
                else if (budget_zero) state_d = S_RESP;
                else                  state_d = S_POLL_ADDR;
            end
            S_SETTLE:     if (settle_zero) state_d = S_FINAL_ADDR;
            S_FINAL_ADDR: state_d = S_FINAL_READ;
            S_FINAL_READ: state_d = S_RESP;
            S_RESP:       state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_q     <= 1'b0;
            toggle_q    <= 1'b0;
            addr_q      <= '0;
            data_q      <= '0;
            idx_q       <= '0;
            prev6_q     <= 1'b0;
            have_prev_q <= 1'b0;
            status_q    <= RSP_OK;
            rdata_q     <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        erase_q  <= req_erase;
                        toggle_q <= req_toggle;
                        addr_q   <= req_addr;
                        data_q   <= req_data;
                        idx_q    <= '0;
                        rdata_q  <= '0;
                        status_q <= out_of_range ? RSP_RANGE : RSP_OK;
                    end
                end
                S_WR_HI: begin
                    if (tbl_last) have_prev_q <= 1'b0;
                    else          idx_q       <= idx_q + 3'd1;
                end
                S_POLL_READ: begin
                    prev6_q     <= fl_din[6];
                    have_prev_q <= 1'b1;
                    if (!complete && budget_zero) status_q <= RSP_TIMEOUT;
                end
                S_FINAL_READ: rdata_q <= fl_din;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == S_IDLE);
        done_valid  = (state_q == S_RESP);
        done_status = status_q;
        done_data   = rdata_q;
        fl_we_n     = 1'b1;
        fl_oe_n     = 1'b1;
        fl_dq_oe    = 1'b0;
        fl_addr     = addr_q;
        fl_dout     = '0;
        unique case (state_q)
            S_WR_LO: begin
                fl_we_n  = 1'b0;
                fl_dq_oe = 1'b1;
                fl_addr  = tbl_addr;
                fl_dout  = tbl_data;
            end
            S_WR_HI: begin
                fl_dq_oe = 1'b1;
                fl_addr  = tbl_addr;
                fl_dout  = tbl_data;
            end
            S_POLL_READ, S_FINAL_READ: fl_oe_n = 1'b0;
            default: ;
        endcase
    end

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
    parameter int AW         = 19,
    parameter int ADDR_LIMIT = 2 ** 19,
    parameter int MAX_POLLS  = 4096
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_erase,
    input logic [AW-1:0] req_addr,
    input logic          done_valid,
    input logic [1:0]    done_status,
    input logic          fl_oe_n,
    input logic          fl_we_n
);

    logic        accept;
    logic        erase_seen;
    logic [31:0] wr_cnt, rd_cnt;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_seen <= 1'b0;
            wr_cnt     <= '0;
            rd_cnt     <= '0;
        end else if (accept) begin
            erase_seen <= req_erase;
            wr_cnt     <= '0;
            rd_cnt     <= '0;
        end else begin
            if (!fl_we_n) wr_cnt <= wr_cnt + 32'd1;
            if (!fl_oe_n) rd_cnt <= rd_cnt + 32'd1;
        end
    end

    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && req_ready));

    assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_oe_n && !fl_we_n));

    assert_read_after_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (wr_cnt == (erase_seen ? 32'd6 : 32'd4)));

    assert_done_after_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_status == 2'd0) |-> $past(!fl_oe_n));

    assert_timeout_budget_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_status == 2'd1) |-> (rd_cnt == 32'(MAX_POLLS)));

    assert_range_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ({1'b0, req_addr} >= (AW + 1)'(ADDR_LIMIT)))
        |=> (done_valid && done_status == 2'd2 && fl_we_n && fl_oe_n));

endmodule

bind flash_poll_ctrl fpc_checker #(
    .AW         (AW),
    .ADDR_LIMIT (ADDR_LIMIT),
    .MAX_POLLS  (MAX_POLLS)
) u_fpc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_erase   (req_erase),
    .req_addr    (req_addr),
    .done_valid  (done_valid),
    .done_status (done_status),
    .fl_oe_n     (fl_oe_n),
    .fl_we_n     (fl_we_n)
);

// File: tb/flash_poll_ctrl_bench.sv
module flash_poll_ctrl_bench;

    localparam int AW   = 16;
    localparam int LIM  = 16'hC000;
    localparam int MAXP = 6;
    localparam int SETL = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_erase = 1'b0, req_toggle = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          req_ready, done_valid, fl_dq_oe, fl_oe_n, fl_we_n;
    logic [1:0]    done_status;
    logic [7:0]    done_data, fl_dout, fl_din;
    logic [AW-1:0] fl_addr;

    always #10 clk = ~clk;

    flash_poll_ctrl #(.AW(AW), .ADDR_LIMIT(LIM), .MAX_POLLS(MAXP), .SETTLE_CYC(SETL))
    u_flash_poll_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_erase(req_erase), .req_toggle(req_toggle), .req_addr(req_addr),
        .req_data(req_data), .done_valid(done_valid), .done_status(done_status),
        .done_data(done_data), .fl_addr(fl_addr), .fl_dout(fl_dout),
        .fl_dq_oe(fl_dq_oe), .fl_din(fl_din), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    int checks = 0, fails = 0;

    // flash model
    logic          cur_erase = 1'b0;
    logic [7:0]    cur_data = '0;
    int            busy_cfg = 0, busy_left = 0;
    logic          tgl = 1'b0;
    int            cyc = 0, acc_cyc = 0, wr_n = 0, rd_n = 0;
    logic          rd_early = 1'b0;
    logic [AW-1:0] wr_a [8];
    logic [7:0]    wr_d [8];
    int            rd_cyc [16];
    logic [7:0]    true_val;

    assign true_val = cur_erase ? 8'hFF : cur_data;
    assign fl_din   = (busy_left > 0)
                    ? {(cur_erase ? 1'b0 : ~cur_data[7]), tgl, 6'b010101} : true_val;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (req_valid && req_ready) begin
            wr_n <= 0; rd_n <= 0; rd_early <= 1'b0; acc_cyc <= cyc + 1;
        end
        if (!fl_we_n) begin
            if (wr_n < 8) begin wr_a[wr_n] <= fl_addr; wr_d[wr_n] <= fl_dout; end
            wr_n <= wr_n + 1; busy_left <= busy_cfg; tgl <= 1'b0;
        end
        if (!fl_oe_n) begin
            if (rd_n < 16) rd_cyc[rd_n] <= cyc + 1;
            rd_n <= rd_n + 1;
            if (busy_left > 0) begin busy_left <= busy_left - 1; tgl <= ~tgl; end
            if (wr_n != (cur_erase ? 6 : 4)) rd_early <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_wa(input bit er, input int i, input int ad);
        if (i == (er ? 5 : 3)) return ad;
        return (i == 1 || i == 4) ? 16'h2AAA : 16'h5555;
    endfunction

    function automatic int exp_wd(input bit er, input int i, input int d);
        if (!er) return (i == 0) ? 8'hAA : (i == 1) ? 8'h55 : (i == 2) ? 8'hA0 : d;
        case (i)
            0, 3: return 8'hAA;
            1, 4: return 8'h55;
            2:    return 8'h80;
            default: return 8'h30;
        endcase
    endfunction

    int done_cyc;

    task automatic issue(input bit er, input bit tg, input logic [AW-1:0] ad,
                         input logic [7:0] d, input int busy);
        int n;
        cur_erase = er; cur_data = d; busy_cfg = busy;
        @(negedge clk);
        req_erase = er; req_toggle = tg; req_addr = ad; req_data = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done_valid && n < 500) begin @(negedge clk); n++; end
        done_cyc = cyc;
        chk(done_valid, "R1", "response seen", done_valid, 1);
    endtask

    task automatic run_op(input bit er, input bit tg, input logic [AW-1:0] ad,
                          input logic [7:0] d, input int busy);
        int k, nw, bad, exp_reads;
        bit ok_exp, v, pv;
        logic [1:0] st;
        logic [7:0] dd;
        issue(er, tg, ad, d, busy);
        st = done_status; dd = done_data;
        // expected completion read index
        if (!tg) k = busy + 1;
        else begin
            k = 40;
            pv = 1'b0;
            for (int j = 1; j < 40; j++) begin
                v = (j <= busy) ? 1'((j - 1) % 2) : true_val[6];
                if (j >= 2 && v == pv) begin k = j; break; end
                pv = v;
            end
        end
        ok_exp = (k <= MAXP);
        exp_reads = ok_exp ? k + 1 : MAXP;
        nw = er ? 6 : 4;
        chk(wr_n == nw, er ? "R3" : "R2", "write count", wr_n, nw);
        bad = 0;
        for (int i = 0; i < nw && i < 8; i++)
            if (wr_a[i] != AW'(exp_wa(er, i, ad)) || wr_d[i] != 8'(exp_wd(er, i, d))) bad++;
        chk(bad == 0, er ? "R3" : "R2", "write words wrong", bad, 0);
        chk(!rd_early, "R4", "read before last write", rd_early, 0);
        chk(st == (ok_exp ? 2'd0 : 2'd1),
            tg ? "R7" : (ok_exp ? (er ? "R6" : "R5") : "R9"), "status", st, ok_exp ? 0 : 1);
        chk(rd_n == exp_reads, tg ? "R7" : (er ? "R6" : "R5"), "read count", rd_n, exp_reads);
        if (ok_exp) begin
            chk(dd == true_val, "R8", "read-back data", dd, true_val);
            chk(rd_cyc[k] - rd_cyc[k - 1] == SETL + 2, "R8", "settle gap",
                rd_cyc[k] - rd_cyc[k - 1], SETL + 2);
        end else begin
            chk(dd == 8'h00, "R9", "timeout data", dd, 0);
        end
        @(negedge clk);
        chk(req_ready && !done_valid, "R1", "back to idle", req_ready, 1);
    endtask

    task automatic run_range(input logic [AW-1:0] ad);
        issue(1'b0, 1'b0, ad, 8'h3C, 0);
        chk(done_status == 2'd2, "R10", "range status", done_status, 2);
        chk(done_data == 8'h00, "R10", "range data", done_data, 0);
        chk(wr_n == 0 && rd_n == 0, "R10", "bus activity", wr_n + rd_n, 0);
        chk(done_cyc == acc_cyc, "R10", "response latency", done_cyc - acc_cyc, 0);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] pats [4];
        pats[0] = 8'h00; pats[1] = 8'h80; pats[2] = 8'h5A; pats[3] = 8'hC3;
        repeat (3) @(negedge clk);
        chk(req_ready && !done_valid && fl_oe_n && fl_we_n && !fl_dq_oe,
            "R11", "reset outputs", {req_ready, done_valid, fl_oe_n, fl_we_n, fl_dq_oe}, 5'b10110);
        rst_n = 1'b1;
        @(negedge clk);
        for (int er = 0; er < 2; er++)
            for (int tg = 0; tg < 2; tg++)
                for (int b = 0; b < 8; b++)
                    for (int p = 0; p < 4; p++)
                        run_op(1'(er), 1'(tg), AW'(16'h1200 + b * 16 + p), pats[p], b);
        run_range(AW'(LIM));
        run_range(16'hFFFF);
        run_op(1'b0, 1'b0, AW'(LIM - 1), 8'h7E, 2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule